// File: doc/BRIEF.md
# Program Counter Sequencer with High-Address Preload

This block holds the 13-bit instruction fetch address of a small core whose instructions are 14 bits wide. It moves the fetch address forward one word at a time. It also redirects the fetch address for jumps, calls, returns, interrupt entry and software writes to the low address byte. Branch instructions carry only an 11-bit target. A 5-bit preload register, which software writes over the data bus, supplies the address bits the instruction cannot reach.

A call or an interrupt entry saves a return address in an eight-entry circular stack, and a return takes it back. The stack has no overflow detection. After a ninth push the oldest entry is silently lost.

The instruction decoder drives one strobe for each kind of control transfer. The preload register and the low address byte live in the global register space, so bank selection never affects them. This block therefore has no bank input.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_ni is low, fetch_addr_o is 0x0000 and preload_o is 0x00.
- R2: With advance_i as the only strobe, the next fetch_addr_o is the current value plus one, and 0x1FFF wraps to 0x0000.
- R3: With no strobe asserted, fetch_addr_o keeps its value.
- R4: A jump_i sets fetch_addr_o to {preload_o[4:3], imm_i[10:0]}.
- R5: A call_i sets fetch_addr_o to {preload_o[4:3], imm_i[10:0]} and pushes the current fetch address plus one.
- R6: A ret_i loads fetch_addr_o from the most recently pushed stack entry and removes that entry.
- R7: A wr_pcl_i sets fetch_addr_o to {preload_o[4:0], wdata_i[7:0]}. If wr_preload_i is asserted in the same cycle, the preload value before that write is the one used.
- R8: A wr_preload_i stores wdata_i[4:0] into preload_o and does not change fetch_addr_o. Without wr_preload_i, preload_o keeps its value.
- R9: An irq_enter_i pushes the current fetch address without incrementing it, and sets fetch_addr_o to 0x0004.
- R10: The stack holds eight entries in a circle. After nine pushes, eight pops return the newest eight in last-in-first-out order, and the ninth pop returns the newest entry again.
- R11: When several control strobes are asserted together, the one that acts is chosen by this priority: irq_enter_i, then wr_pcl_i, then call_i, then jump_i, then ret_i, then advance_i. wr_preload_i acts independently of all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| advance_i | input | 1 | Step to the next sequential word |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| irq_enter_i | input | 1 | Interrupt entry strobe |
| imm_i | input | 11 | Branch target field of the instruction |
| wr_pcl_i | input | 1 | Software write to the low address byte |
| wr_preload_i | input | 1 | Software write to the preload register |
| wdata_i | input | 8 | Data bus for both register writes |
| fetch_addr_o | output | 13 | Fetch address |
| preload_o | output | 5 | Preload register contents, for read-back |

## Verification
The assertions check several behaviours on every cycle: the sequential increment, holding the address, the branch target formed from preload bits 4:3, the computed target formed from all five preload bits, the preload write and hold, and the interrupt vector. Return addresses depend on what was pushed earlier, possibly many cycles before. So return order, the circular overwrite after nine pushes, the pushed value (incremented for a call but not for an interrupt) and the reset values are shown only by the bench's scenarios.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_RET,
    SEL_BRANCH,
    SEL_PCL,
    SEL_VEC
  } pc_sel_e;
endpackage

// File: rtl/pc_ctrl_dec.sv
module pc_ctrl_dec
  import pc_seq_pkg::*;
(
  input  logic    advance_i,
  input  logic    jump_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    irq_enter_i,
  input  logic    wr_pcl_i,
  output pc_sel_e sel_o,
  output logic    push_o,
  output logic    push_inc_o,
  output logic    pop_o
);
  // fixed priority: irq > pcl write > call > jump > ret > advance
  always_comb begin
    sel_o      = SEL_HOLD;
    push_o     = 1'b0;
    push_inc_o = 1'b0;
    pop_o      = 1'b0;
    if (irq_enter_i) begin
      sel_o  = SEL_VEC;
      push_o = 1'b1;
    end else if (wr_pcl_i) begin
      sel_o = SEL_PCL;
    end else if (call_i) begin
      sel_o      = SEL_BRANCH;
      push_o     = 1'b1;
      push_inc_o = 1'b1;
    end else if (jump_i) begin
      sel_o = SEL_BRANCH;
    end else if (ret_i) begin
      sel_o = SEL_RET;
      pop_o = 1'b1;
    end else if (advance_i) begin
      sel_o = SEL_INC;
    end
  end
endmodule

// File: rtl/pc_preload_reg.sv
module pc_preload_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PL_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PL_W-1:0]   q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i[PL_W-1:0];
  end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr;
  logic [W-1:0]     slot_rd [DEPTH];

  // pointer wraps modulo DEPTH; no overflow or underflow tracking
  assign rd_ptr = (wr_ptr_q == '0) ? LAST : wr_ptr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
    end else if (push_i) begin
      wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    end else if (pop_i) begin
      wr_ptr_q <= rd_ptr;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr_q == PTR_W'(e)) slot_q <= push_data_i;
    end
    assign slot_rd[e] = slot_q;
  end

  assign top_o = slot_rd[rd_ptr];
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int unsigned PC_W      = 13,
  parameter int unsigned IMM_W     = 11,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned IRQ_VEC   = 4,
  parameter int unsigned PL_W      = PC_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              irq_enter_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              wr_pcl_i,
  input  logic              wr_preload_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PC_W-1:0]   fetch_addr_o,
  output logic [PL_W-1:0]   preload_o
);
  localparam int unsigned HI_W = PC_W - IMM_W;

  pc_sel_e          sel;
  logic             push, push_inc, pop;
  logic [PC_W-1:0]  pc_q, pc_d, pc_inc, stack_top, push_data;
  logic [PL_W-1:0]  pl_q;

  pc_ctrl_dec u_dec (
    .advance_i  (advance_i),
    .jump_i     (jump_i),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .irq_enter_i(irq_enter_i),
    .wr_pcl_i   (wr_pcl_i),
    .sel_o      (sel),
    .push_o     (push),
    .push_inc_o (push_inc),
    .pop_o      (pop)
  );

  pc_preload_reg #(.DATA_W(DATA_W), .PL_W(PL_W)) u_preload (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_preload_i),
    .wdata_i(wdata_i),
    .q_o    (pl_q)
  );

  assign pc_inc    = pc_q + 1'b1;
  assign push_data = push_inc ? pc_inc : pc_q;

  pc_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_data_i(push_data),
    .top_o      (stack_top)
  );

  always_comb begin
    unique case (sel)
      SEL_INC:    pc_d = pc_inc;
      SEL_RET:    pc_d = stack_top;
      SEL_BRANCH: pc_d = {pl_q[PL_W-1 -: HI_W], imm_i};
      SEL_PCL:    pc_d = {pl_q, wdata_i};
      SEL_VEC:    pc_d = PC_W'(IRQ_VEC);
      default:    pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign fetch_addr_o = pc_q;
  assign preload_o    = pl_q;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int unsigned PC_W    = 13,
  parameter int unsigned IMM_W   = 11,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IRQ_VEC = 4,
  parameter int unsigned PL_W    = PC_W - DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              advance_i,
  input logic              jump_i,
  input logic              call_i,
  input logic              ret_i,
  input logic              irq_enter_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              wr_pcl_i,
  input logic              wr_preload_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [PC_W-1:0]   fetch_addr_o,
  input logic [PL_W-1:0]   preload_o
);
  localparam int unsigned HI_W = PC_W - IMM_W;

  logic any_ctl;
  assign any_ctl = advance_i | jump_i | call_i | ret_i | irq_enter_i | wr_pcl_i;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !jump_i && !call_i && !ret_i && !irq_enter_i && !wr_pcl_i)
      |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_ctl |=> $stable(fetch_addr_o));

  p_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !call_i && !irq_enter_i && !wr_pcl_i)
      |=> fetch_addr_o == {$past(preload_o[PL_W-1 -: HI_W]), $past(imm_i)});

  p_call_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !irq_enter_i && !wr_pcl_i)
      |=> fetch_addr_o == {$past(preload_o[PL_W-1 -: HI_W]), $past(imm_i)});

  p_pcl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pcl_i && !irq_enter_i)
      |=> fetch_addr_o == {$past(preload_o), $past(wdata_i)});

  p_preload_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_preload_i |=> preload_o == $past(wdata_i[PL_W-1:0]));

  p_preload_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_preload_i |=> $stable(preload_o));

  p_vector_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_enter_i |=> fetch_addr_o == PC_W'(IRQ_VEC));
endmodule

bind pc_sequencer pc_sequencer_chk #(
  .PC_W(PC_W), .IMM_W(IMM_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC), .PL_W(PL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .advance_i   (advance_i),
  .jump_i      (jump_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .irq_enter_i (irq_enter_i),
  .imm_i       (imm_i),
  .wr_pcl_i    (wr_pcl_i),
  .wr_preload_i(wr_preload_i),
  .wdata_i     (wdata_i),
  .fetch_addr_o(fetch_addr_o),
  .preload_o   (preload_o)
);

// File: tb/pc_sequencer_tb_top.sv
`timescale 1ns/1ps
module pc_sequencer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        advance_i = 1'b0, jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic        irq_enter_i = 1'b0, wr_pcl_i = 1'b0, wr_preload_i = 1'b0;
  logic [10:0] imm_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [12:0] fetch_addr_o;
  logic [4:0]  preload_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pc_sequencer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .advance_i(advance_i), .jump_i(jump_i),
    .call_i(call_i), .ret_i(ret_i), .irq_enter_i(irq_enter_i), .imm_i(imm_i),
    .wr_pcl_i(wr_pcl_i), .wr_preload_i(wr_preload_i), .wdata_i(wdata_i),
    .fetch_addr_o(fetch_addr_o), .preload_o(preload_o)
  );

  // strobes {irq, pcl, call, jump, ret, adv, wpre}, imm, wdata, exp pc, exp preload, req
  localparam int NV = 21;
  localparam logic [47:0] VECS [NV] = '{
    {7'b0000010, 11'h000, 8'h00, 13'h0001, 5'h00, 4'd2},  // R2
    {7'b0000010, 11'h000, 8'h00, 13'h0002, 5'h00, 4'd2},  // R2
    {7'b0000001, 11'h000, 8'h1B, 13'h0002, 5'h1B, 4'd8},  // R8 pc unchanged
    {7'b0001000, 11'h123, 8'h00, 13'h1923, 5'h1B, 4'd4},  // R4
    {7'b0000010, 11'h000, 8'h00, 13'h1924, 5'h1B, 4'd2},  // R2
    {7'b0010000, 11'h055, 8'h00, 13'h1855, 5'h1B, 4'd5},  // R5 push 0x1925
    {7'b0000010, 11'h000, 8'h00, 13'h1856, 5'h1B, 4'd2},  // R2
    {7'b0000100, 11'h000, 8'h00, 13'h1925, 5'h1B, 4'd6},  // R6
    {7'b0100000, 11'h000, 8'h80, 13'h1B80, 5'h1B, 4'd7},  // R7
    {7'b0100001, 11'h000, 8'hE4, 13'h1BE4, 5'h04, 4'd7},  // R7 old preload used
    {7'b1000010, 11'h000, 8'h00, 13'h0004, 5'h04, 4'd9},  // R9 push 0x1BE4
    {7'b0000010, 11'h000, 8'h00, 13'h0005, 5'h04, 4'd2},  // R2
    {7'b0000100, 11'h000, 8'h00, 13'h1BE4, 5'h04, 4'd6},  // R6
    {7'b0000000, 11'h000, 8'h00, 13'h1BE4, 5'h04, 4'd3},  // R3
    {7'b0011110, 11'h100, 8'h00, 13'h0100, 5'h04, 4'd11}, // R11 call wins
    {7'b1100000, 11'h000, 8'h33, 13'h0004, 5'h04, 4'd11}, // R11 irq wins
    {7'b0000100, 11'h000, 8'h00, 13'h0100, 5'h04, 4'd6},  // R6
    {7'b0000100, 11'h000, 8'h00, 13'h1BE5, 5'h04, 4'd6},  // R6
    {7'b0000001, 11'h000, 8'hFF, 13'h1BE5, 5'h1F, 4'd8},  // R8
    {7'b0100000, 11'h000, 8'hFF, 13'h1FFF, 5'h1F, 4'd7},  // R7
    {7'b0000010, 11'h000, 8'h00, 13'h0000, 5'h1F, 4'd2}   // R2 wrap
  };

  task automatic drive(input logic [6:0] s, input logic [10:0] imm, input logic [7:0] wd);
    @(negedge clk_i);
    {irq_enter_i, wr_pcl_i, call_i, jump_i, ret_i, advance_i, wr_preload_i} = s;
    imm_i   = imm;
    wdata_i = wd;
    @(negedge clk_i);
    {irq_enter_i, wr_pcl_i, call_i, jump_i, ret_i, advance_i, wr_preload_i} = '0;
  endtask

  task automatic expect_out(input int req, input logic [12:0] epc, input logic [4:0] epl);
    n_chk++;
    if (fetch_addr_o !== epc || preload_o !== epl) begin
      n_bad++;
      $display("FAIL R%0d: pc=%h preload=%h expected pc=%h preload=%h",
               req, fetch_addr_o, preload_o, epc, epl);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    expect_out(1, 13'h0000, 5'h00); // R1 during reset
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][47:41], VECS[i][40:30], VECS[i][29:22]);
      expect_out(int'(VECS[i][3:0]), VECS[i][21:9], VECS[i][8:4]);
    end
    // R1: reset from a non-zero state
    drive(7'b0000010, '0, '0);
    expect_out(2, 13'h0001, 5'h1F);
    rst_ni = 1'b0;
    #1;
    expect_out(1, 13'h0000, 5'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: nine pushes via interrupt entry, then nine returns
    drive(7'b0000001, '0, 8'h1F);
    expect_out(8, 13'h0000, 5'h1F);
    for (int k = 1; k <= 9; k++) begin
      drive(7'b0100000, '0, 8'(k));
      expect_out(7, 13'h1F00 + 13'(k), 5'h1F);
      drive(7'b1000000, '0, '0);
      expect_out(9, 13'h0004, 5'h1F);
    end
    for (int j = 0; j < 8; j++) begin
      drive(7'b0000100, '0, '0);
      expect_out(10, 13'h1F09 - 13'(j), 5'h1F);
    end
    drive(7'b0000100, '0, '0);
    expect_out(10, 13'h1F09, 5'h1F); // R10 wrapped slot returns newest
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL all requirements: watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule